// File: doc/BRIEF.md
# Transmit Status Drain Engine

This engine empties a hardware transmit-status queue. The queue shows itself as two 32-bit words at fixed addresses: a status word and a companion word. A start pulse begins a drain. Each pass reads the status word once and then the companion word once, over a register read port with request/acknowledge handshaking. The two words are folded into a 14-byte little-endian status record.

Records whose pending flag is clear go out on a valid/ready stream. Each record comes with its decoded fields: internal ID, attempt count, ACK flag, NACK flag and sequence number. Records whose pending flag is set are counted and dropped. The drain ends when a status word arrives with bit 0 clear, and an all-zero word counts as this case. The engine then pulses `done_o` for one cycle and goes back to idle.

The FSM has five states:
- `ST_IDLE`: waiting for start.
- `ST_RD_STAT`: reading the status word.
- `ST_RD_COMP`: reading the companion word.
- `ST_EMIT`: offering a record on the stream.
- `ST_FINISH`: the one-cycle done pulse.

Its transitions are:
- IDLE→RD_STAT on start.
- RD_STAT→RD_COMP on a response with bit 0 set.
- RD_STAT→FINISH on a response with bit 0 clear.
- RD_COMP→EMIT on a response whose record is not pending.
- RD_COMP→RD_STAT on a response whose record is pending (a drop).
- EMIT→RD_STAT when the record is accepted.
- FINISH→IDLE unconditionally.

Top module: `txs_drain`

## Requirements
- R1: A `start_i` pulse in idle begins a drain. A `start_i` seen while a drain is in progress has no effect, so no extra reads and no second done pulse follow.
- R2: Each pass issues exactly one read at `STAT_ADDR` (0x170), then exactly one read at `COMP_ADDR` (0x174). `rd_req_o` stays high and `rd_addr_o` stays stable until `rd_ack_i`, and read data is taken in the cycle of the acknowledge.
- R3: A status response with bit 0 clear, including all-zero, ends the drain. No companion read follows, `done_o` is high for exactly one cycle, and the engine returns to idle.
- R4: Byte k of `rec_bytes_o` occupies bits [8k+7:8k]. The byte layout is:
  - Bytes 4–5 hold status[31:16] in little-endian order.
  - Bytes 10–11 hold companion[15:0] in little-endian order.
  - Byte 12 holds companion[23:16].
  - Bytes 0–3, 8–9 and 13 are zero.
- R5: Byte 6 is {status[7:4], companion[24], status[3:1]}, which is the low nibble shifted right by one with companion bit 24 merged into bit 3. Byte 7 (flags) is status[15:8].
- R6: The decoded fields are:
  - `rec_id_o` = status[31:16]
  - `rec_tries_o` = status[7:4], the upper nibble of byte 6
  - `rec_ack_o` = flag bit 0 (status[8])
  - `rec_nack_o` = flag bit 7 (status[15])
  - `rec_seq_o` = companion[15:0]
- R7: A record whose flag bit 5 (status[13]) is set is never emitted, and it increments `drop_cnt_o`.
- R8: While `rec_valid_o` is high and `rec_ready_i` is low, `rec_valid_o` stays high and the record stays stable. Each accepted record increments `emit_cnt_o`.
- R9: Both counters clear when a drain starts, saturate at 2^CNT_W−1, and hold their values after the drain ends.
- R10: After reset, `rd_req_o`, `rec_valid_o`, `done_o`, both counters and all record outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a drain (ignored while busy) |
| rd_req_o | output | 1 | Register read request |
| rd_addr_o | output | ADDR_W | Register read address |
| rd_ack_i | input | 1 | Read response valid |
| rd_data_i | input | 32 | Read response data |
| rec_valid_o | output | 1 | Record stream valid |
| rec_ready_i | input | 1 | Record stream ready |
| rec_bytes_o | output | 112 | 14-byte status record, byte k at [8k+7:8k] |
| rec_id_o | output | 16 | Internal ID |
| rec_tries_o | output | 4 | Attempt count |
| rec_ack_o | output | 1 | ACK received flag |
| rec_nack_o | output | 1 | NACK flag |
| rec_seq_o | output | 16 | Sequence number |
| done_o | output | 1 | One-cycle pulse when the queue is found empty |
| emit_cnt_o | output | CNT_W | Records emitted in this drain (saturating) |
| drop_cnt_o | output | CNT_W | Pending records dropped in this drain (saturating) |

## Verification
The assertions check several properties on every cycle:
- Read requests are held with a stable address until acknowledged.
- A status response with bit 0 set is followed at once by a companion read.
- A status response with bit 0 clear leads straight to a single done pulse.
- A pending record never appears on the stream.
- A stalled record stays intact.
- A saturated counter stays saturated.

Other behaviours only the bench scenarios can show:
- The byte layout, including the nibble shift and the bit-24 merge.
- The decoded fields.
- The exact read sequence for a whole drain.
- The counter totals after mixed pending and non-pending records.
- Saturation at the counter limit.
- That a start pulse during a drain changes nothing.

// File: rtl/txs_pkg.sv
package txs_pkg;
    localparam int WORD_W    = 32;
    localparam int REC_BYTES = 14;
    localparam int REC_W     = REC_BYTES * 8;
    localparam int ID_BYTE   = 4;
    localparam int CTL_BYTE  = 6;
    localparam int FLAG_BYTE = 7;
    localparam int SEQ_BYTE  = 10;
    localparam int XTRA_BYTE = 12;
    localparam int FLG_ACK   = 0;
    localparam int FLG_PEND  = 5;
    localparam int FLG_NACK  = 7;
    localparam int MERGE_BIT = 24;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_STAT,
        ST_RD_COMP,
        ST_EMIT,
        ST_FINISH
    } drain_st_e;
endpackage

// File: rtl/txs_fmt.sv
module txs_fmt
    import txs_pkg::*;
(
    input  logic [WORD_W-1:0] stat_w,
    input  logic [WORD_W-1:0] comp_w,
    output logic [REC_W-1:0]  rec,
    output logic              pend
);
    logic [15:0] ctl;

    always_comb begin
        // control half-word: low nibble shifted down, companion flag merged at bit 3
        ctl = {stat_w[15:4], comp_w[MERGE_BIT], stat_w[3:1]};
        rec = '0;
        rec[ID_BYTE*8   +: 16] = stat_w[31:16];
        rec[CTL_BYTE*8  +: 16] = ctl;
        rec[SEQ_BYTE*8  +: 16] = comp_w[15:0];
        rec[XTRA_BYTE*8 +: 8]  = comp_w[23:16];
        pend = ctl[8 + FLG_PEND];
    end
endmodule

// File: rtl/txs_dec.sv
module txs_dec
    import txs_pkg::*;
(
    input  logic [REC_W-1:0] rec,
    output logic [15:0]      id,
    output logic [3:0]       tries,
    output logic             ack,
    output logic             nack,
    output logic [15:0]      seq
);
    always_comb begin
        id    = {rec[(ID_BYTE+1)*8 +: 8], rec[ID_BYTE*8 +: 8]};
        tries = rec[CTL_BYTE*8 + 4 +: 4];
        ack   = rec[FLAG_BYTE*8 + FLG_ACK];
        nack  = rec[FLAG_BYTE*8 + FLG_NACK];
        seq   = {rec[(SEQ_BYTE+1)*8 +: 8], rec[SEQ_BYTE*8 +: 8]};
    end
endmodule

// File: rtl/txs_satcnt.sv
module txs_satcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] MAXV = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    q <= '0;
        else if (clr)                  q <= '0;
        else if (inc && (q != MAXV))   q <= q + 1'b1;
    end

    // R9
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q == MAXV) && !clr |=> (q == MAXV));

    // R9
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr && !inc |=> $stable(q));
endmodule

// File: rtl/txs_drain.sv
module txs_drain
    import txs_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 12'h170,
    parameter logic [ADDR_W-1:0] COMP_ADDR = 12'h174,
    parameter int                CNT_W     = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    output logic                rd_req_o,
    output logic [ADDR_W-1:0]   rd_addr_o,
    input  logic                rd_ack_i,
    input  logic [WORD_W-1:0]   rd_data_i,
    output logic                rec_valid_o,
    input  logic                rec_ready_i,
    output logic [REC_W-1:0]    rec_bytes_o,
    output logic [15:0]         rec_id_o,
    output logic [3:0]          rec_tries_o,
    output logic                rec_ack_o,
    output logic                rec_nack_o,
    output logic [15:0]         rec_seq_o,
    output logic                done_o,
    output logic [CNT_W-1:0]    emit_cnt_o,
    output logic [CNT_W-1:0]    drop_cnt_o
);
    drain_st_e          st_q, st_d;
    logic [WORD_W-1:0]  stat_q;
    logic [REC_W-1:0]   rec_q;
    logic [REC_W-1:0]   fmt_rec;
    logic               fmt_pend;
    logic               stat_hit, comp_hit;
    logic               cnt_clr, emit_inc, drop_inc;

    txs_fmt u_fmt (
        .stat_w (stat_q),
        .comp_w (rd_data_i),
        .rec    (fmt_rec),
        .pend   (fmt_pend)
    );

    assign stat_hit = (st_q == ST_RD_STAT) && rd_ack_i;
    assign comp_hit = (st_q == ST_RD_COMP) && rd_ack_i;
    assign cnt_clr  = (st_q == ST_IDLE) && start_i;
    assign emit_inc = (st_q == ST_EMIT) && rec_ready_i;
    assign drop_inc = comp_hit && fmt_pend;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:    if (start_i) st_d = ST_RD_STAT;
            ST_RD_STAT: if (rd_ack_i) st_d = rd_data_i[0] ? ST_RD_COMP : ST_FINISH;
            ST_RD_COMP: if (rd_ack_i) st_d = fmt_pend ? ST_RD_STAT : ST_EMIT;
            ST_EMIT:    if (rec_ready_i) st_d = ST_RD_STAT;
            ST_FINISH:  st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rd_req_o    = (st_q == ST_RD_STAT) || (st_q == ST_RD_COMP);
        rd_addr_o   = (st_q == ST_RD_COMP) ? COMP_ADDR : STAT_ADDR;
        rec_valid_o = (st_q == ST_EMIT);
        done_o      = (st_q == ST_FINISH);
    end

    // captured words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            rec_q  <= '0;
        end else begin
            if (stat_hit)              stat_q <= rd_data_i;
            if (comp_hit && !fmt_pend) rec_q  <= fmt_rec;
        end
    end

    assign rec_bytes_o = rec_q;

    txs_dec u_dec (
        .rec   (rec_q),
        .id    (rec_id_o),
        .tries (rec_tries_o),
        .ack   (rec_ack_o),
        .nack  (rec_nack_o),
        .seq   (rec_seq_o)
    );

    txs_satcnt #(.W(CNT_W)) u_emit_cnt (
        .clk (clk), .rst_n (rst_n), .clr (cnt_clr), .inc (emit_inc), .q (emit_cnt_o)
    );

    txs_satcnt #(.W(CNT_W)) u_drop_cnt (
        .clk (clk), .rst_n (rst_n), .clr (cnt_clr), .inc (drop_inc), .q (drop_cnt_o)
    );

    // R2
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_addr_o));

    // R2
    comp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o && rd_ack_i && (rd_addr_o == STAT_ADDR) && rd_data_i[0]
        |=> rd_req_o && (rd_addr_o == COMP_ADDR));

    // R3
    empty_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o && rd_ack_i && (rd_addr_o == STAT_ADDR) && !rd_data_i[0] |=> done_o);

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o && !rd_req_o && !rec_valid_o);

    // R7
    no_pend_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid_o |-> !rec_bytes_o[FLAG_BYTE*8 + FLG_PEND]);

    // R8
    rec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid_o && !rec_ready_i |=> rec_valid_o && $stable(rec_bytes_o));

    // R8
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rec_valid_o && rd_req_o));
endmodule

// File: tb/txs_drain_bench.sv
`timescale 1ns/1ps
module txs_drain_bench;
    localparam int CW = 3;
    localparam logic [11:0] SA = 12'h170;
    localparam logic [11:0] CA = 12'h174;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic rd_req_o, rd_ack_i = 1'b0;
    logic [11:0] rd_addr_o;
    logic [31:0] rd_data_i = '0;
    logic rec_valid_o, rec_ready_i = 1'b0;
    logic [111:0] rec_bytes_o;
    logic [15:0] rec_id_o, rec_seq_o;
    logic [3:0] rec_tries_o;
    logic rec_ack_o, rec_nack_o, done_o;
    logic [CW-1:0] emit_cnt_o, drop_cnt_o;

    txs_drain #(.CNT_W(CW)) u_txs_drain (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
        .rec_valid_o(rec_valid_o), .rec_ready_i(rec_ready_i), .rec_bytes_o(rec_bytes_o),
        .rec_id_o(rec_id_o), .rec_tries_o(rec_tries_o), .rec_ack_o(rec_ack_o),
        .rec_nack_o(rec_nack_o), .rec_seq_o(rec_seq_o), .done_o(done_o),
        .emit_cnt_o(emit_cnt_o), .drop_cnt_o(drop_cnt_o)
    );

    always #2.5 clk = ~clk;

    int nchk = 0, nfail = 0;
    logic [31:0] src_stat[$], src_comp[$];
    logic [31:0] term_w = '0;
    int lat = 0, rdy_mode = 0, idx = 0, wcnt = 0, done_cnt = 0, cyc = 0;
    bit rdy_ph = 1'b0;
    bit rd_log[$];
    logic [111:0] got_rec[$];
    logic [37:0]  got_fld[$];

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [111:0] exp_rec(input logic [31:0] s, input logic [31:0] c);
        logic [111:0] r;
        r = '0;
        r[39:32]   = s[23:16];
        r[47:40]   = s[31:24];
        r[55:48]   = {s[7:4], c[24], s[3:1]};
        r[63:56]   = s[15:8];
        r[87:80]   = c[7:0];
        r[95:88]   = c[15:8];
        r[103:96]  = c[23:16];
        return r;
    endfunction

    function automatic logic [37:0] exp_fld(input logic [31:0] s, input logic [31:0] c);
        return {s[31:16], s[7:4], s[8], s[15], c[15:0]};
    endfunction

    // responder and monitor: everything decided at the falling edge
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nfail++; nchk++;
            $display("FAIL watchdog: actual %0d expected <150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
        rd_ack_i = 1'b0;
        if (rst_n && rd_req_o) begin
            if (wcnt >= lat) begin
                rd_ack_i = 1'b1;
                wcnt = 0;
                if (rd_addr_o == SA) begin
                    rd_data_i = (idx < src_stat.size()) ? src_stat[idx] : term_w;
                    rd_log.push_back(1'b0);
                end else begin
                    rd_data_i = (idx < src_comp.size()) ? src_comp[idx] : 32'h0;
                    idx++;
                    rd_log.push_back(1'b1);
                end
            end else wcnt++;
        end
        rdy_ph = ~rdy_ph;
        rec_ready_i = (rdy_mode == 0) ? 1'b1 : rdy_ph;
        if (rst_n && rec_valid_o && rec_ready_i) begin
            got_rec.push_back(rec_bytes_o);
            got_fld.push_back({rec_id_o, rec_tries_o, rec_ack_o, rec_nack_o, rec_seq_o});
        end
        if (done_o) done_cnt++;
    end

    task automatic launch();
        idx = 0; wcnt = 0;
        rd_log.delete(); got_rec.delete(); got_fld.delete();
        done_cnt = 0;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (done_cnt == 0 && n < 3000) begin @(negedge clk); n++; end
        chk(done_cnt != 0, {tag, " R3 drain ends"}, done_cnt, 1);
        repeat (4) @(negedge clk);
    endtask

    task automatic verify(input string tag);
        int ne = 0, nd = 0, k = 0, mx;
        bit seq_ok = 1'b1;
        mx = (1 << CW) - 1;
        foreach (src_stat[i]) begin
            if (src_stat[i][13]) nd++;
            else begin
                if (k < got_rec.size()) begin
                    chk(got_rec[k] == exp_rec(src_stat[i], src_comp[i]), {tag, " R4/R5 record bytes"},
                        got_rec[k], exp_rec(src_stat[i], src_comp[i]));
                    chk(got_fld[k] == exp_fld(src_stat[i], src_comp[i]), {tag, " R6 decoded fields"},
                        got_fld[k], exp_fld(src_stat[i], src_comp[i]));
                end
                k++; ne++;
            end
        end
        chk(got_rec.size() == ne, {tag, " R7 emitted count"}, got_rec.size(), ne);
        chk(rd_log.size() == 2*src_stat.size()+1, {tag, " R2 read count"}, rd_log.size(), 2*src_stat.size()+1);
        foreach (rd_log[i]) if (rd_log[i] != (i % 2)) seq_ok = 1'b0;
        chk(seq_ok, {tag, " R2 read order"}, seq_ok, 1);
        chk(done_cnt == 1, {tag, " R3 single done"}, done_cnt, 1);
        chk(emit_cnt_o == CW'((ne > mx) ? mx : ne), {tag, " R9 emit counter"}, emit_cnt_o, (ne > mx) ? mx : ne);
        chk(drop_cnt_o == CW'((nd > mx) ? mx : nd), {tag, " R9 drop counter"}, drop_cnt_o, (nd > mx) ? mx : nd);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!rd_req_o && !rec_valid_o && !done_o, "R10 reset controls", {rd_req_o, rec_valid_o, done_o}, 0);
        chk(emit_cnt_o == 0 && drop_cnt_o == 0, "R10 reset counters", {emit_cnt_o, drop_cnt_o}, 0);
        chk(rec_bytes_o == 0 && rec_id_o == 0 && rec_seq_o == 0, "R10 reset record", rec_bytes_o, 0);
    endtask

    task automatic t_basic();
        src_stat = '{32'h1234_8153, 32'hBEEF_004F};
        src_comp = '{32'h0100_ABCD, 32'h00FF_1234};
        term_w = 32'h0; lat = 0; rdy_mode = 0;
        launch(); wait_done("basic"); verify("basic");
    endtask

    task automatic t_zero();
        src_stat.delete(); src_comp.delete();
        term_w = 32'h0; lat = 1; rdy_mode = 0;
        launch(); wait_done("zero"); verify("zero");
    endtask

    task automatic t_pending();
        src_stat = '{32'h0001_2031, 32'h0002_0111, 32'h0003_3F01, 32'h0004_8009};
        src_comp = '{32'h0111_0001, 32'h0022_0002, 32'h0133_0003, 32'h0044_0004};
        term_w = 32'h5555_AAAA; lat = 0; rdy_mode = 0;
        launch(); wait_done("pending"); verify("pending");
    endtask

    task automatic t_stall();
        src_stat = '{32'hA5A5_C0F1, 32'h0F0F_0E03, 32'h7777_9195};
        src_comp = '{32'h01AB_CDEF, 32'h0000_FFFF, 32'h0155_0102};
        term_w = 32'h0; lat = 3; rdy_mode = 1;
        launch(); wait_done("stall R8"); verify("stall R8");
        rdy_mode = 0;
    endtask

    task automatic t_saturate();
        src_stat.delete(); src_comp.delete();
        for (int i = 0; i < 18; i++) begin
            src_stat.push_back({16'(i + 16'h100), 8'((i % 2) ? 8'h21 : 8'h11), 8'h31});
            src_comp.push_back({8'h00, 8'(i), 16'(i * 3)});
        end
        term_w = 32'h0; lat = 0; rdy_mode = 0;
        launch(); wait_done("saturate R9"); verify("saturate R9");
    endtask

    task automatic t_start_busy();
        src_stat = '{32'h0042_0113, 32'h0043_0025};
        src_comp = '{32'h0000_0010, 32'h0100_0011};
        term_w = 32'h0; lat = 2; rdy_mode = 0;
        launch();
        repeat (3) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        wait_done("busy start R1");
        repeat (6) @(negedge clk);
        verify("busy start R1");
        chk(!rd_req_o, "R1 no restart after done", rd_req_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_basic();
        t_zero();
        t_pending();
        t_stall();
        t_saturate();
        t_start_busy();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule